// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block runs the link-integrity state machine of a twisted-pair 10 Mb/s transceiver. Digitized receive events come in as one-cycle strobes: a link pulse detected on the receive pair, or valid receive data. From these the block decides whether the link is up (pass) or down (fail). While the link is up and the transmitter is idle, it sends a periodic link pulse strobe so that the far end can monitor the medium. The link state controls the enables for the transmit driver, the receiver, the loopback path and collision detection. It also drives an active-low link status output and a link-fail status bit. When a frame is sent while the link is down, the block flags the frame with a loss-of-carrier error and a collision error.

A disable input suits partners that do not send link pulses. When it is set, the data paths stay enabled whatever the receive pair shows. A sleep input has three behaviours. The wake options are sampled on the cycle that sleep is first seen high, and stay fixed until sleep drops. With no wake option, everything is frozen and dark. The receive-wake option keeps link detection and the status output running. The full-wake option keeps the receiver and transmitter running and hands the status pin over to the external decode outputs. Both wake options silence outgoing link pulses.

Top module: `tp_link_monitor`

## Requirements
- R1: After reset the link is in fail: `link_fail`=1, `link_st_n`=1, all four path enables are 0, and no link pulse is emitted.
- R2: In fail, `PASS_PULSES` consecutive received link pulses (default 6, one more than five) move the link to pass on the clock edge that samples the last pulse. Fewer pulses leave it in fail.
- R3: Two received pulses count as consecutive only if they are at most `MAX_GAP` cycles apart. A longer gap clears the count, and counting restarts from the next pulse.
- R4: In fail, a single `rx_data` strobe moves the link to pass on the edge that samples it.
- R5: In pass, the link falls to fail exactly `LOSS_CYCLES` cycles after the last edge that saw `rx_pulse` or `rx_data` (or after entry to pass).
- R6: `link_fail` is 1 in fail and 0 in pass. While the status output is enabled, `link_st_n` is the inverse of pass. Whenever `link_st_oe`=0, `link_st_n` is held at 1.
- R7: With link test enabled, `tx_en`, `rx_en`, `lpbk_en` and `col_en` are 0 in fail and 1 in pass while awake.
- R8: With `lt_disable`=1 and awake, all four enables are 1 whatever the link state.
- R9: In pass, awake and with `tx_busy`=0, `lt_pulse_out` is a one-cycle strobe every `PULSE_PERIOD` cycles. The first comes `PULSE_PERIOD-1` cycles after the pulse timer is enabled. Any busy cycle restarts the interval, and no pulse is sent in fail.
- R10: One cycle after each `tx_frame_done` strobe, `fr_vld`=1 and both `fr_lcar` and `fr_cerr` equal (link in fail AND `lt_disable`=0) as sampled with the strobe.
- R11: Sleep with `wake_rx`=1 (and `wake_full`=0): the receiver and link detection keep running, and `link_st_n` tracks the link with `link_st_oe`=1. `tx_en`, `lpbk_en`, `col_en` and `frame_tx_allow` are 0, and no link pulse is sent.
- R12: Sleep with `wake_full`=1: all four enables follow the link, `dec_oe`=1, `link_st_oe`=0, `frame_tx_allow`=0, and no link pulse is sent. Wake inputs changed during sleep have no effect.
- R13: Sleep with neither wake option: all enables are 0, both output enables are 0, and the link state and its timers are frozen until sleep drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lt_disable | input | 1 | Disables link test gating of the data paths |
| wake_rx | input | 1 | Receive-wake option, sampled when sleep rises |
| wake_full | input | 1 | Full-wake option, sampled when sleep rises (wins over `wake_rx`) |
| sleep | input | 1 | Sleep request |
| rx_pulse | input | 1 | Strobe: link test pulse received |
| rx_data | input | 1 | Strobe: valid receive data |
| tx_busy | input | 1 | Transmit path busy |
| tx_frame_done | input | 1 | Strobe: a frame was transmitted |
| lt_pulse_out | output | 1 | Strobe: send one link test pulse |
| tx_en | output | 1 | Transmit driver enable |
| rx_en | output | 1 | Receive data path enable |
| lpbk_en | output | 1 | Loopback path enable |
| col_en | output | 1 | Collision detection enable |
| link_st_n | output | 1 | Link status, low when link is up |
| link_st_oe | output | 1 | Link status output enable |
| link_fail | output | 1 | Link-fail status bit |
| dec_oe | output | 1 | External decode outputs enable |
| frame_tx_allow | output | 1 | MAC may start a frame |
| fr_vld | output | 1 | Frame status valid strobe |
| fr_lcar | output | 1 | Loss-of-carrier flag for the reported frame |
| fr_cerr | output | 1 | Collision error flag for the reported frame |

## Verification
A wrong pulse count or a bad gap counter shows up as `link_fail` dropping one pulse early or late, or not at all. The bench sweeps pulse counts and gap lengths on either side of the limits and checks the state on the cycle right after the deciding pulse. A silence timer that is off by one moves the fall into fail by a cycle, so the bench checks both the last pass cycle and the first fail cycle. A slip in the transmit pulse timer puts `lt_pulse_out` on the wrong cycle. Every cycle of the pass interval is compared with the period formula. A bad sleep mode register shows at once on the enables and the output-enable pins one cycle after sleep is raised.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic {
    LNK_FAIL = 1'b0,
    LNK_PASS = 1'b1
  } link_e;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_DOZE  = 2'd1,
    PM_RXWK  = 2'd2,
    PM_FULWK = 2'd3
  } pmode_e;
endpackage

// File: rtl/lt_loss_timer.sv
module lt_loss_timer #(
  parameter int LOSS_CYCLES = 2000000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  input  logic armed,
  input  logic evt,
  output logic expire
);
  localparam int CW = $clog2(LOSS_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(LOSS_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (!armed || evt)      cnt_d = '0;
      else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign expire = en && armed && !evt && (cnt_q == LAST);
endmodule

// File: rtl/lt_fail_exit.sv
module lt_fail_exit #(
  parameter int PASS_PULSES = 6,
  parameter int MAX_GAP     = 480000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  input  logic armed,
  input  logic pulse,
  output logic qualify
);
  localparam int PW = $clog2(PASS_PULSES);
  localparam int GW = $clog2(MAX_GAP);
  localparam logic [PW-1:0] PLAST = PW'(PASS_PULSES - 1);
  localparam logic [GW-1:0] GLAST = GW'(MAX_GAP - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [GW-1:0] gap_q, gap_d;

  always_comb begin
    pcnt_d = pcnt_q;
    gap_d  = gap_q;
    if (en) begin
      if (!armed) begin
        pcnt_d = '0;
        gap_d  = '0;
      end else if (pulse) begin
        gap_d  = '0;
        pcnt_d = (pcnt_q == PLAST) ? '0 : pcnt_q + 1'b1;
      end else if (gap_q == GLAST) begin
        pcnt_d = '0;
      end else begin
        gap_d = gap_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      gap_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      gap_q  <= gap_d;
    end
  end

  assign qualify = en && armed && pulse && (pcnt_q == PLAST);
endmodule

// File: rtl/lt_pulse_gen.sv
module lt_pulse_gen #(
  parameter int PULSE_PERIOD = 320000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic en,
  output logic strobe
);
  localparam int CW = $clog2(PULSE_PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PULSE_PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en)                cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign strobe = en && (cnt_q == LAST);
endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor
  import lt_pkg::*;
#(
  parameter int LOSS_CYCLES  = 2000000,
  parameter int PULSE_PERIOD = 320000,
  parameter int MAX_GAP      = 480000,
  parameter int PASS_PULSES  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lt_disable,
  input  logic wake_rx,
  input  logic wake_full,
  input  logic sleep,
  input  logic rx_pulse,
  input  logic rx_data,
  input  logic tx_busy,
  input  logic tx_frame_done,
  output logic lt_pulse_out,
  output logic tx_en,
  output logic rx_en,
  output logic lpbk_en,
  output logic col_en,
  output logic link_st_n,
  output logic link_st_oe,
  output logic link_fail,
  output logic dec_oe,
  output logic frame_tx_allow,
  output logic fr_vld,
  output logic fr_lcar,
  output logic fr_cerr
);
  // reset: asserted at once, released two edges later
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // power mode, wake choice frozen while asleep
  pmode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (!sleep)                mode_d = PM_RUN;
    else if (mode_q == PM_RUN) mode_d = wake_full ? PM_FULWK :
                                        (wake_rx ? PM_RXWK : PM_DOZE);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mode_q <= PM_RUN;
    else         mode_q <= mode_d;
  end

  logic det_en, tx_side_on, rx_side_on;
  assign det_en     = (mode_q != PM_DOZE);
  assign rx_side_on = (mode_q != PM_DOZE);
  assign tx_side_on = (mode_q == PM_RUN) || (mode_q == PM_FULWK);

  // link state
  link_e state_q, state_d;
  logic  loss_expire, exit_qual, rx_evt;

  assign rx_evt = rx_pulse || rx_data;

  lt_loss_timer #(.LOSS_CYCLES(LOSS_CYCLES)) u_loss (
    .clk    (clk),
    .rst_ni (rst_ni),
    .en     (det_en),
    .armed  (state_q == LNK_PASS),
    .evt    (rx_evt),
    .expire (loss_expire)
  );

  lt_fail_exit #(.PASS_PULSES(PASS_PULSES), .MAX_GAP(MAX_GAP)) u_exit (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .en      (det_en),
    .armed   (state_q == LNK_FAIL),
    .pulse   (rx_pulse),
    .qualify (exit_qual)
  );

  always_comb begin
    state_d = state_q;
    if (det_en) begin
      case (state_q)
        LNK_FAIL: if (rx_data || exit_qual) state_d = LNK_PASS;
        LNK_PASS: if (loss_expire)          state_d = LNK_FAIL;
        default:                            state_d = LNK_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= LNK_FAIL;
    else         state_q <= state_d;
  end

  // outgoing link pulses
  logic pgen_en;
  assign pgen_en = (state_q == LNK_PASS) && (mode_q == PM_RUN) && !tx_busy;

  lt_pulse_gen #(.PULSE_PERIOD(PULSE_PERIOD)) u_pgen (
    .clk    (clk),
    .rst_ni (rst_ni),
    .en     (pgen_en),
    .strobe (lt_pulse_out)
  );

  // path enables and status pins
  logic link_ok;
  assign link_ok        = (state_q == LNK_PASS) || lt_disable;
  assign tx_en          = tx_side_on && link_ok;
  assign lpbk_en        = tx_side_on && link_ok;
  assign col_en         = tx_side_on && link_ok;
  assign rx_en          = rx_side_on && link_ok;
  assign link_st_oe     = (mode_q == PM_RUN) || (mode_q == PM_RXWK);
  assign link_st_n      = !(link_st_oe && (state_q == LNK_PASS));
  assign link_fail      = (state_q == LNK_FAIL);
  assign dec_oe         = (mode_q == PM_FULWK);
  assign frame_tx_allow = (mode_q == PM_RUN);

  // per-frame transmit status
  logic fr_vld_q, fr_err_q, fr_err_d;
  assign fr_err_d = tx_frame_done && (state_q == LNK_FAIL) && !lt_disable;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_vld_q <= 1'b0;
      fr_err_q <= 1'b0;
    end else begin
      fr_vld_q <= tx_frame_done;
      fr_err_q <= fr_err_d;
    end
  end

  assign fr_vld  = fr_vld_q;
  assign fr_lcar = fr_err_q;
  assign fr_cerr = fr_err_q;
endmodule

// File: rtl/tp_link_monitor_chk.sv
module tp_link_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic lt_disable,
  input logic sleep,
  input logic rx_data,
  input logic tx_busy,
  input logic tx_frame_done,
  input logic lt_pulse_out,
  input logic tx_en,
  input logic rx_en,
  input logic lpbk_en,
  input logic col_en,
  input logic link_st_n,
  input logic link_st_oe,
  input logic link_fail,
  input logic dec_oe,
  input logic frame_tx_allow,
  input logic fr_lcar,
  input logic fr_cerr
);
  // R7
  gate_in_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fail && !lt_disable) |-> !(tx_en || rx_en || lpbk_en || col_en));

  // R8
  disable_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_disable && !sleep && !$past(sleep)) |-> (tx_en && rx_en && lpbk_en && col_en));

  // R6
  fail_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |-> link_st_n);

  // R9
  pulse_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_pulse_out |-> (!link_fail && !tx_busy && !sleep));

  // R4
  data_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fail && rx_data && !sleep && !$past(sleep)) |=> !link_fail);

  // R10
  frame_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_frame_done && link_fail && !lt_disable) |=> (fr_lcar && fr_cerr));

  // R12
  full_wake_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_oe |-> (!link_st_oe && link_st_n && !frame_tx_allow));
endmodule

bind tp_link_monitor tp_link_monitor_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lt_disable     (lt_disable),
  .sleep          (sleep),
  .rx_data        (rx_data),
  .tx_busy        (tx_busy),
  .tx_frame_done  (tx_frame_done),
  .lt_pulse_out   (lt_pulse_out),
  .tx_en          (tx_en),
  .rx_en          (rx_en),
  .lpbk_en        (lpbk_en),
  .col_en         (col_en),
  .link_st_n      (link_st_n),
  .link_st_oe     (link_st_oe),
  .link_fail      (link_fail),
  .dec_oe         (dec_oe),
  .frame_tx_allow (frame_tx_allow),
  .fr_lcar        (fr_lcar),
  .fr_cerr        (fr_cerr)
);

// File: tb/tp_link_monitor_test.sv
module tp_link_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int LOSS = 40;
  localparam int PER  = 10;
  localparam int GAP  = 8;
  localparam int NP   = 6;

  logic clk = 1'b0;
  logic rst_n, lt_disable, wake_rx, wake_full, sleep;
  logic rx_pulse, rx_data, tx_busy, tx_frame_done;
  logic lt_pulse_out, tx_en, rx_en, lpbk_en, col_en, link_st_n, link_st_oe;
  logic link_fail, dec_oe, frame_tx_allow, fr_vld, fr_lcar, fr_cerr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tp_link_monitor #(
    .LOSS_CYCLES(LOSS), .PULSE_PERIOD(PER), .MAX_GAP(GAP), .PASS_PULSES(NP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .lt_disable(lt_disable), .wake_rx(wake_rx),
    .wake_full(wake_full), .sleep(sleep), .rx_pulse(rx_pulse), .rx_data(rx_data),
    .tx_busy(tx_busy), .tx_frame_done(tx_frame_done), .lt_pulse_out(lt_pulse_out),
    .tx_en(tx_en), .rx_en(rx_en), .lpbk_en(lpbk_en), .col_en(col_en),
    .link_st_n(link_st_n), .link_st_oe(link_st_oe), .link_fail(link_fail),
    .dec_oe(dec_oe), .frame_tx_allow(frame_tx_allow), .fr_vld(fr_vld),
    .fr_lcar(fr_lcar), .fr_cerr(fr_cerr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send_pulse();
    rx_pulse = 1'b1;
    tick();
    rx_pulse = 1'b0;
  endtask

  task automatic send_data();
    rx_data = 1'b1;
    tick();
    rx_data = 1'b0;
  endtask

  task automatic send_frame();
    tx_frame_done = 1'b1;
    tick();
    tx_frame_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lt_disable = 1'b0; wake_rx = 1'b0; wake_full = 1'b0;
    sleep = 1'b0; rx_pulse = 1'b0; rx_data = 1'b0; tx_busy = 1'b0;
    tx_frame_done = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  function automatic int enables();
    return {28'd0, tx_en, rx_en, lpbk_en, col_en};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int npulses;
    do_reset();
    // R1 reset state
    chk("R1 link_fail", link_fail, 1);
    chk("R1 link_st_n", link_st_n, 1);
    chk("R1 enables", enables(), 0);
    chk("R1 pulse", lt_pulse_out, 0);

    // R2 sweep pulse count, spacing 3
    for (int n = 1; n <= NP + 1; n++) begin
      do_reset();
      for (int i = 0; i < n; i++) begin send_pulse(); idle(2); end
      chk($sformatf("R2 count %0d", n), link_fail, (n < NP) ? 1 : 0);
    end

    // R3 sweep spacing around the gap limit
    for (int g = 2; g <= GAP + 3; g++) begin
      do_reset();
      for (int i = 0; i < NP; i++) begin send_pulse(); idle(g - 1); end
      chk($sformatf("R3 spacing %0d", g), link_fail, (g > GAP) ? 1 : 0);
    end

    // R3 long gap clears a partial count
    do_reset();
    for (int i = 0; i < 3; i++) begin send_pulse(); idle(1); end
    idle(GAP + 1);
    for (int i = 0; i < 3; i++) begin send_pulse(); idle(1); end
    chk("R3 count cleared", link_fail, 1);
    for (int i = 0; i < 3; i++) begin send_pulse(); idle(1); end
    chk("R3 recount to pass", link_fail, 0);

    // R4 data exits fail; R6/R7 pass outputs; R9/R5 pass interval
    do_reset();
    send_data();
    chk("R4 data exit", link_fail, 0);
    chk("R6 status low", link_st_n, 0);
    chk("R7 enables on", enables(), 15);
    npulses = 0;
    for (int k = 0; k < LOSS; k++) begin
      chk($sformatf("R9 pulse k=%0d", k), lt_pulse_out, (k % PER == PER - 1) ? 1 : 0);
      chk("R5 still pass", link_fail, 0);
      tick();
    end
    chk("R5 fail after silence", link_fail, 1);
    chk("R6 status high", link_st_n, 1);
    chk("R7 enables off", enables(), 0);
    chk("R9 no pulse in fail", lt_pulse_out, 0);

    // R5 a received pulse restarts the silence timer
    send_data();
    idle(LOSS - 10);
    send_pulse();
    idle(LOSS - 1);
    chk("R5 refreshed pass", link_fail, 0);
    idle(1);
    chk("R5 refreshed fail", link_fail, 1);

    // R9 busy transmit suppresses and restarts the interval
    send_data();
    tx_busy = 1'b1;
    for (int k = 0; k < 2 * PER; k++) begin
      if (lt_pulse_out) npulses++;
      tick();
    end
    chk("R9 none while busy", npulses, 0);
    tx_busy = 1'b0;
    for (int k = 0; k < PER; k++) begin
      chk($sformatf("R9 restart k=%0d", k), lt_pulse_out, (k == PER - 1) ? 1 : 0);
      tick();
    end

    // R10 frame flags in pass, fail, and fail with test disabled
    send_frame();
    chk("R10 vld", fr_vld, 1);
    chk("R10 pass lcar", fr_lcar, 0);
    chk("R10 pass cerr", fr_cerr, 0);
    idle(LOSS);
    chk("R10 now fail", link_fail, 1);
    send_frame();
    chk("R10 fail lcar", fr_lcar, 1);
    chk("R10 fail cerr", fr_cerr, 1);
    tick();
    chk("R10 vld one cycle", fr_vld, 0);
    lt_disable = 1'b1;
    tick();
    // R8
    chk("R8 enables forced", enables(), 15);
    chk("R8 fail bit kept", link_fail, 1);
    send_frame();
    chk("R10 disabled lcar", fr_lcar, 0);
    lt_disable = 1'b0;
    tick();
    chk("R7 enables off again", enables(), 0);

    // R11 receive wake
    do_reset();
    send_data();
    wake_rx = 1'b1; sleep = 1'b1;
    tick();
    chk("R11 enables rx only", enables(), 4);
    chk("R11 status low", link_st_n, 0);
    chk("R11 status oe", link_st_oe, 1);
    chk("R11 no frames", frame_tx_allow, 0);
    npulses = 0;
    for (int k = 0; k < 2 * PER; k++) begin
      if (lt_pulse_out) npulses++;
      tick();
    end
    chk("R11 no pulses", npulses, 0);
    idle(LOSS);
    chk("R11 detects fail", link_fail, 1);
    chk("R11 status high", link_st_n, 1);
    send_data();
    chk("R11 detects pass", link_st_n, 0);
    sleep = 1'b0; wake_rx = 1'b0;
    tick();

    // R12 full wake
    do_reset();
    send_data();
    wake_full = 1'b1; sleep = 1'b1;
    tick();
    chk("R12 enables", enables(), 15);
    chk("R12 dec_oe", dec_oe, 1);
    chk("R12 status oe", link_st_oe, 0);
    chk("R12 status pin", link_st_n, 1);
    chk("R12 no frames", frame_tx_allow, 0);
    wake_full = 1'b0;
    npulses = 0;
    for (int k = 0; k < 2 * PER; k++) begin
      if (lt_pulse_out) npulses++;
      tick();
    end
    chk("R12 no pulses", npulses, 0);
    chk("R12 wake change ignored", dec_oe, 1);
    sleep = 1'b0;
    tick();
    chk("R12 awake again", frame_tx_allow, 1);

    // R13 plain sleep freezes state
    do_reset();
    send_data();
    sleep = 1'b1;
    tick();
    chk("R13 enables off", enables(), 0);
    chk("R13 status oe", link_st_oe, 0);
    chk("R13 dec_oe", dec_oe, 0);
    idle(2 * LOSS);
    sleep = 1'b0;
    tick();
    chk("R13 pass frozen", link_fail, 0);
    do_reset();
    sleep = 1'b1;
    tick();
    send_data();
    sleep = 1'b0;
    tick();
    chk("R13 data ignored", link_fail, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule